// File: doc/BRIEF.md
# External Interrupt Pin Detector

This block watches one asynchronous interrupt pin on behalf of a processor. It brings the pin into the clock domain and detects transitions toward a selectable active level. It keeps a sticky status flag and raises an interrupt request when that flag is set and interrupts are enabled. The block also drives a control for the pad's internal pull device, choosing between pull-up and pull-down to match the selected polarity, and it offers the synchronized pin level for software polling.

Software programs the block through one 8-bit control/status register. A single write both sets the configuration and may request a flag clear through a write-only acknowledge bit. Two detection modes exist. In edge-only mode, a transition sets the flag and an acknowledge clears it. In edge-and-level mode, the flag also stays pinned high, and acknowledges are refused, for as long as the pin sits at its active level. Turning the pin on while it already rests at its active level produces a spurious flag. The safe sequence is: keep interrupts masked, enable the pin, acknowledge, then unmask.

Top module: `irqpin_top`

## Requirements
- R1: `pin_level` equals the value of `pin_raw` as sampled two rising clock edges earlier (a two-stage synchronizer). It is not altered by polarity.
- R2: After reset, every control bit is 0, the flag is 0, `rd_data` reads 0x00, `irq` is 0, and the pull device is off.
- R3: `pull_on` is 1 exactly when bit 0 (pin enable) is 1 and bit 3 (pull disable) is 0. `pull_up` is 1 only while `pull_on` is 1 and bit 1 (polarity) is 0. A value of 0 in bit 1 means falling/low active and 1 means rising/high active.
- R4: While enabled, a change of the synchronized pin from its inactive to its active level sets the flag (bit 6) one clock after the change shows on `pin_level`.
- R5: Writing with bit 5 (acknowledge) set clears the flag, unless R6 or R7 applies. Bit 5 always reads as 0.
- R6: With bit 2 (mode) at 1, the flag is held at 1 and acknowledges have no effect for as long as the synchronized pin stays active. An acknowledge after the pin becomes inactive clears the flag.
- R7: When an acknowledge and a detected edge fall in the same cycle, the flag ends up set.
- R8: `irq` is 1 exactly when the flag is 1 and bit 4 (interrupt enable) is 1.
- R9: While bit 0 is 0, pin activity never sets the flag and the edge history is reset to inactive. Enabling the pin while it rests at its active level sets the flag one clock after the enabling write.
- R10: `rd_data` returns bits 0..4 as last written, the flag in bit 6, and 0 in bits 5 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_raw | input | 1 | Asynchronous external interrupt pin |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register read value |
| pin_level | output | 1 | Synchronized pin level |
| pull_on | output | 1 | Internal pull device enable |
| pull_up | output | 1 | Pull direction, 1 = up, 0 = down |
| irq | output | 1 | Interrupt request |

## Verification
The bound checker tests the following on every cycle: that a detected edge or an active level in hold mode leaves the flag set, that an acknowledge clears the flag when nothing opposes it, that a disabled pin never raises the flag, and that the request and pull outputs respect their gating. Some behaviour depends on how stimulus is placed in time, and only the bench scenarios show it. This covers the exact two-cycle synchronizer latency, an acknowledge colliding with an edge, and the spurious flag after enabling the pin with the clearing sequence that keeps `irq` low throughout.

// File: rtl/irqpin_pkg.sv
package irqpin_pkg;

    localparam int REG_W   = 8;
    localparam int B_EN    = 0;
    localparam int B_POL   = 1;
    localparam int B_MODE  = 2;
    localparam int B_PDIS  = 3;
    localparam int B_IE    = 4;
    localparam int B_ACK   = 5;
    localparam int B_FLAG  = 6;

    typedef struct packed {
        logic ie;
        logic pdis;
        logic mode;
        logic pol;
        logic en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic logic active_of(input logic lvl, input logic pol);
        return pol ? lvl : ~lvl;
    endfunction

    function automatic logic [REG_W-1:0] status_word(input ctrl_t c, input logic flag);
        logic [REG_W-1:0] w;
        w              = '0;
        w[CTRL_W-1:0]  = c;
        w[B_FLAG]      = flag;
        return w;
    endfunction

endpackage

// File: rtl/irqpin_sync.sv
module irqpin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/irqpin_ctrl.sv
module irqpin_ctrl
    import irqpin_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output ctrl_t            ctrl_q,
    output logic             ack
);
    always_ff @(posedge clk) begin
        if (rst)        ctrl_q <= '0;
        else if (wr_en) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
    end

    assign ack = wr_en & wr_data[B_ACK];
endmodule

// File: rtl/irqpin_detect.sv
module irqpin_detect
    import irqpin_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctrl_t ctrl,
    input  logic  lvl,
    input  logic  ack,
    output logic  active,
    output logic  hist_q,
    output logic  flag_q
);
    logic edge_hit;
    logic hold;
    logic flag_d;

    assign active   = active_of(lvl, ctrl.pol);
    assign edge_hit = ctrl.en & active & ~hist_q;
    assign hold     = ctrl.en & ctrl.mode & active;

    always_comb begin
        flag_d = flag_q;
        if (ack && !hold)     flag_d = 1'b0;
        if (edge_hit || hold) flag_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            hist_q <= ctrl.en & active;
            flag_q <= flag_d;
        end
    end
endmodule

// File: rtl/irqpin_top.sv
module irqpin_top
    import irqpin_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pin_raw,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             pin_level,
    output logic             pull_on,
    output logic             pull_up,
    output logic             irq
);
    ctrl_t ctrl_q;
    logic  ack;
    logic  active;
    logic  hist_q;
    logic  flag_q;

    irqpin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (pin_raw),
        .dout(pin_level)
    );

    irqpin_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .ctrl_q (ctrl_q),
        .ack    (ack)
    );

    irqpin_detect u_det (
        .clk   (clk),
        .rst   (rst),
        .ctrl  (ctrl_q),
        .lvl   (pin_level),
        .ack   (ack),
        .active(active),
        .hist_q(hist_q),
        .flag_q(flag_q)
    );

    assign pull_on = ctrl_q.en & ~ctrl_q.pdis;
    assign pull_up = pull_on & ~ctrl_q.pol;
    assign irq     = flag_q & ctrl_q.ie;
    assign rd_data = status_word(ctrl_q, flag_q);
endmodule

// File: rtl/irqpin_checker.sv
module irqpin_checker (
    input logic       clk,
    input logic       rst,
    input logic       en,
    input logic       mode,
    input logic       ie,
    input logic       active,
    input logic       hist_q,
    input logic       ack,
    input logic       flag_q,
    input logic       irq,
    input logic       pull_on,
    input logic [7:0] rd_data
);
    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (rst)
        (en && active && !hist_q) |=> flag_q);                          // R4
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (ack && !(en && active && !hist_q) && !(en && mode && active)) |=> !flag_q); // R5
    AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (en && mode && active) |=> flag_q);                             // R6
    AST_NO_SET_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (!en && !flag_q) |=> !flag_q);                                  // R9
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ie && flag_q));                                        // R8
    AST_PULL_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        !en |-> !pull_on);                                              // R3
    AST_ACK_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_data[5] == 1'b0);                                            // R10
endmodule

bind irqpin_top irqpin_checker u_chk (
    .clk    (clk),
    .rst    (rst),
    .en     (ctrl_q.en),
    .mode   (ctrl_q.mode),
    .ie     (ctrl_q.ie),
    .active (active),
    .hist_q (hist_q),
    .ack    (ack),
    .flag_q (flag_q),
    .irq    (irq),
    .pull_on(pull_on),
    .rd_data(rd_data)
);

// File: tb/irqpin_top_tb_top.sv
module irqpin_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pin_raw = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       pin_level, pull_on, pull_up, irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irqpin_top dut_i (
        .clk(clk), .rst(rst), .pin_raw(pin_raw), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .pin_level(pin_level), .pull_on(pull_on),
        .pull_up(pull_up), .irq(irq)
    );

    // behavioural reference model
    bit       m_pipe[$];
    bit [4:0] m_cfg;
    bit       m_flag;
    bit       m_last;

    initial begin
        m_pipe = '{1'b0, 1'b0};
        m_cfg = '0; m_flag = 0; m_last = 0;
    end

    always @(posedge clk) begin
        if (rst) begin
            m_pipe = '{1'b0, 1'b0};
            m_cfg = '0; m_flag = 0; m_last = 0;
        end else begin
            bit act, e, hld, ak;
            act = m_cfg[1] ? m_pipe[0] : !m_pipe[0];
            e   = m_cfg[0] && act && !m_last;
            hld = m_cfg[0] && m_cfg[2] && act;
            ak  = wr_en && wr_data[5];
            if (ak && !hld) m_flag = 0;
            if (e || hld)   m_flag = 1;
            m_last = m_cfg[0] ? act : 1'b0;
            if (wr_en) m_cfg = wr_data[4:0];
            m_pipe.push_back(pin_raw);
            void'(m_pipe.pop_front());
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            bit [7:0] exp_rd;
            bit       exp_pon;
            exp_rd  = {1'b0, m_flag, 1'b0, m_cfg};
            exp_pon = m_cfg[0] && !m_cfg[3];
            check(pin_level == m_pipe[0], "R1 pin_level", pin_level, m_pipe[0]);
            check(rd_data == exp_rd, "R10 rd_data", rd_data, exp_rd);
            check(pull_on == exp_pon, "R3 pull_on", pull_on, exp_pon);
            check(pull_up == (exp_pon && !m_cfg[1]), "R3 pull_up", pull_up, exp_pon && !m_cfg[1]);
            check(irq == (m_flag && m_cfg[4]), "R8 irq", irq, m_flag && m_cfg[4]);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input bit [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        bit irq_seen;
        tick(3);
        rst = 1'b0;
        tick(1);
        check(rd_data == 8'h00 && irq == 0 && pull_on == 0, "R2 reset state", rd_data, 0);

        // pull device control
        wr(8'h03);                               // en, rising
        check(pull_on && !pull_up, "R3 pulldown", {pull_on, pull_up}, 2'b10);
        wr(8'h01);                               // en, falling
        check(pull_on && pull_up, "R3 pullup", {pull_on, pull_up}, 2'b11);
        wr(8'h09);                               // pull disabled
        check(!pull_on && !pull_up, "R3 pull off", {pull_on, pull_up}, 2'b00);

        // edge-only rising: latency and ack
        wr(8'h23);                               // rising, ack to clear any flag
        tick(2);
        @(negedge clk) pin_raw = 1'b1;
        tick(2);
        check(pin_level == 1 && rd_data[6] == 0, "R1 two-stage latency", {pin_level, rd_data[6]}, 2'b10);
        tick(1);
        check(rd_data[6] == 1, "R4 flag after edge", rd_data[6], 1);
        wr(8'h23);
        check(rd_data[6] == 0 && rd_data[5] == 0, "R5 ack clears, reads 0", rd_data[7:5], 0);

        // request gating
        @(negedge clk) pin_raw = 1'b0;
        tick(3);
        wr(8'h13);                               // ie on
        @(negedge clk) pin_raw = 1'b1;
        tick(3);
        check(irq == 1, "R8 irq with ie", irq, 1);
        wr(8'h03);
        check(irq == 0 && rd_data[6] == 1, "R8 irq masked", {irq, rd_data[6]}, 2'b01);

        // edge-and-level mode
        wr(8'h07);
        wr(8'h27);                               // ack while pin active
        tick(1);
        check(rd_data[6] == 1, "R6 ack refused while active", rd_data[6], 1);
        @(negedge clk) pin_raw = 1'b0;
        tick(3);
        wr(8'h27);
        check(rd_data[6] == 0, "R6 ack after inactive", rd_data[6], 0);

        // edge and ack in the same cycle
        wr(8'h03);
        @(negedge clk) pin_raw = 1'b1;
        tick(2);                                 // edge is evaluated at the next posedge
        wr_en = 1'b1; wr_data = 8'h23;
        @(negedge clk) begin wr_en = 1'b0; wr_data = '0; end
        check(rd_data[6] == 1, "R7 edge wins over ack", rd_data[6], 1);
        wr(8'h23);

        // disabled pin ignores activity
        wr(8'h22);                               // en off, rising, ack
        @(negedge clk) pin_raw = 1'b0;
        tick(3);
        @(negedge clk) pin_raw = 1'b1;
        tick(4);
        check(rd_data[6] == 0, "R9 no flag while disabled", rd_data[6], 0);

        // spurious flag on enable and safe clearing sequence
        irq_seen = 0;
        @(negedge clk) begin wr_en = 1'b1; wr_data = 8'h03; end
        @(negedge clk) begin wr_en = 1'b0; wr_data = '0; irq_seen |= irq; end
        check(rd_data[6] == 0, "R9 flag not yet set", rd_data[6], 0);
        @(negedge clk) irq_seen |= irq;
        check(rd_data[6] == 1, "R9 spurious flag on enable", rd_data[6], 1);
        wr(8'h23);
        irq_seen |= irq;
        check(rd_data[6] == 0, "R5 ack removes spurious flag", rd_data[6], 0);
        wr(8'h13);
        irq_seen |= irq;
        tick(2);
        irq_seen |= irq;
        check(irq_seen == 0, "R8 request never raised", irq_seen, 0);

        tick(2);
        finish_run();
    end
endmodule